// File: doc/BRIEF.md
# Power and Sleep Controller

This block gates the clocks and local resets of a small set of modules, each of which belongs to a power domain. Software controls it through a plain register read/write port. A request is staged before it takes effect. Software writes a wanted state and a local-reset control into a per-module control word, and may set a power-on request in a per-domain control word. Nothing changes at the outputs until software writes a start bit for the domain.

When it accepts a start bit, the controller takes a snapshot of the staged requests of every module in that domain. It then raises a per-domain busy flag for a fixed number of cycles set by a parameter. At the end of that window, every module of the domain moves to its snapshot state at once, the domain state is updated, and the busy flag drops. Software polls the busy flag and then reads the module status word, which holds the current state and a clock-running indication. Each module has a registered clock-enable output and a registered reset output, both derived from its current state.

Module i sits at offset 4*i within its register page. Domain d also sits at offset 4*d within its page. Reads return data one cycle after the read strobe.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, every module status reads 0, every module control word reads 0, every domain status reads 0, the busy register at 0x128 reads 0, every clock-enable output is 0 and every reset output is 1.
- R2: A module control word at 0xA00+4*i stores the requested state in bits 5:0 and the active-low local-reset control in bit 8. All other bits read back as 0.
- R3: Writing 1 to bit d of the start register at 0x120 sets bit d of the busy register at 0x128. The bit stays 1 for exactly TRANS_CYCLES cycles and then clears.
- R4: On the cycle that a domain's busy bit clears, bits 5:0 of the status word at 0x800+4*i of every module in that domain take the requested state captured at the start. The status of modules in other domains is unchanged.
- R5: Status bit 12 and the module's clock-enable output are 1 exactly when the current state is 3 (enable). State codes are 0 software-reset-disable, 1 synchronous reset, 2 disable, 3 enable.
- R6: A module's reset output is 1 when its current state is 0 or 1, or when the local-reset control captured at the start was 0.
- R7: Domain status at 0x200+4*d reads 0 while the domain is off. When a transition ends, its bits 4:0 become 1 if bit 0 of the domain control word at 0x300+4*d was set when the start was accepted, and 0 if it was clear.
- R8: A start bit written to a domain that is already busy is ignored: the busy window is not extended or restarted.
- R9: Module control writes made while a domain is busy do not affect that transition. They apply only at the next accepted start.
- R10: Several domains can be started by one write. Each domain runs its own window and finishes independently.
- R11: Reads of unmapped offsets, and of module or domain indices that do not exist, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module reset, active high |

## Verification
The bench counts the busy reads after a start, one per cycle. A window that is off by one cycle, or that restarts on a second start bit, therefore shows up as a wrong count. It changes a module's control word while its domain is busy and checks that the status keeps the old snapshot. A design that reads the live control word at completion would report the new state too early. A reference model tracks the staged and applied state of every module. After each transition the bench compares all modules with this model, so a design that also updates modules in the other domain, or that ties the clock or reset output to the wrong state codes, fails. Domain power-on, both domains started by one write, and the zero readback of unmapped addresses are also checked.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int STATE_W   = 6;
  localparam int LRST_BIT  = 8;
  localparam int CLKON_BIT = 12;
  localparam int DSTAT_W   = 5;

  localparam logic [11:0] OFF_START = 12'h120;
  localparam logic [11:0] OFF_BUSY  = 12'h128;

  localparam logic [3:0] PG_DSTAT = 4'h2;
  localparam logic [3:0] PG_DCTL  = 4'h3;
  localparam logic [3:0] PG_MSTAT = 4'h8;
  localparam logic [3:0] PG_MCTL  = 4'hA;

  typedef enum logic [STATE_W-1:0] {
    MS_SWRST_OFF = 6'd0,
    MS_SYNC_RST  = 6'd1,
    MS_DISABLE   = 6'd2,
    MS_ENABLE    = 6'd3
  } mod_state_e;

  localparam logic [DSTAT_W-1:0] DOM_ON_CODE = 5'd1;
endpackage

// File: rtl/psc_regif.sv
module psc_regif
  import psc_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int N_DOM = 2,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [N_DOM-1:0]   start_bits,
  input  logic [N_MOD*DW-1:0] mctl_words,
  input  logic [N_MOD*DW-1:0] mstat_words,
  input  logic [N_DOM*DW-1:0] dctl_words,
  input  logic [N_DOM*DW-1:0] dstat_words,
  input  logic [N_DOM-1:0]   dom_busy,
  output logic [N_MOD-1:0]   mctl_we,
  output logic [N_DOM-1:0]   dctl_we,
  output logic [N_DOM-1:0]   start_req,
  output logic [DW-1:0]      bus_rdata
);
  localparam int IDX_W = 6;

  logic [3:0]       page;
  logic [IDX_W-1:0] idx;
  logic             word_ok;
  logic [DW-1:0]    rd_mux;

  assign page    = bus_addr[11:8];
  assign idx     = bus_addr[7:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);

  for (genvar m = 0; m < N_MOD; m++) begin : g_mwe
    assign mctl_we[m] = bus_wr && word_ok && (page == PG_MCTL) && (idx == IDX_W'(m));
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dwe
    assign dctl_we[d] = bus_wr && word_ok && (page == PG_DCTL) && (idx == IDX_W'(d));
  end

  assign start_req = (bus_wr && bus_addr == AW'(OFF_START)) ? start_bits : '0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFF_BUSY)) begin
      rd_mux[N_DOM-1:0] = dom_busy;
    end else if (word_ok) begin
      for (int m = 0; m < N_MOD; m++) begin
        if (idx == IDX_W'(m) && page == PG_MSTAT) rd_mux = mstat_words[m*DW +: DW];
        if (idx == IDX_W'(m) && page == PG_MCTL)  rd_mux = mctl_words[m*DW +: DW];
      end
      for (int d = 0; d < N_DOM; d++) begin
        if (idx == IDX_W'(d) && page == PG_DSTAT) rd_mux = dstat_words[d*DW +: DW];
        if (idx == IDX_W'(d) && page == PG_DCTL)  rd_mux = dctl_words[d*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/psc_dom_seq.sv
module psc_dom_seq
  import psc_pkg::*;
#(
  parameter int TRANS_CYCLES = 8,
  parameter int DW           = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ctl_we,
  input  logic          ctl_pwr_bit,
  output logic          busy,
  output logic          accept,
  output logic          done,
  output logic [DW-1:0] ctl_word,
  output logic [DW-1:0] stat_word
);
  localparam int CNT_W = $clog2(TRANS_CYCLES + 1);

  logic [CNT_W-1:0]   cnt;
  logic               pwr_req;
  logic               pwr_snap;
  logic [DSTAT_W-1:0] dom_state;

  assign accept = start && !busy;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pwr_req   <= 1'b0;
      pwr_snap  <= 1'b0;
      dom_state <= '0;
    end else begin
      if (ctl_we) pwr_req <= ctl_pwr_bit;
      if (accept) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(TRANS_CYCLES - 1);
        pwr_snap <= pwr_req;
      end else if (done) begin
        busy      <= 1'b0;
        dom_state <= pwr_snap ? DOM_ON_CODE : '0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    ctl_word             = '0;
    ctl_word[0]          = pwr_req;
    stat_word            = '0;
    stat_word[DSTAT_W-1:0] = dom_state;
  end
endmodule

// File: rtl/psc_mod_unit.sv
module psc_mod_unit
  import psc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [STATE_W-1:0] wr_state,
  input  logic               wr_lrst_n,
  input  logic               accept,
  input  logic               done,
  output logic [DW-1:0]      ctl_word,
  output logic [DW-1:0]      stat_word,
  output logic [STATE_W-1:0] cur_state,
  output logic               clk_en,
  output logic               mod_rst
);
  logic [STATE_W-1:0] req_state;
  logic               req_lrst_n;
  logic [STATE_W-1:0] snap_state;
  logic               snap_lrst_n;
  logic               in_reset_state;

  assign in_reset_state = (snap_state == MS_SWRST_OFF) || (snap_state == MS_SYNC_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_state   <= '0;
      req_lrst_n  <= 1'b0;
      snap_state  <= '0;
      snap_lrst_n <= 1'b0;
      cur_state   <= '0;
      clk_en      <= 1'b0;
      mod_rst     <= 1'b1;
    end else begin
      if (ctl_we) begin
        req_state  <= wr_state;
        req_lrst_n <= wr_lrst_n;
      end
      if (accept) begin
        snap_state  <= req_state;
        snap_lrst_n <= req_lrst_n;
      end
      if (done) begin
        cur_state <= snap_state;
        clk_en    <= (snap_state == MS_ENABLE);
        mod_rst   <= in_reset_state || !snap_lrst_n;
      end
    end
  end

  always_comb begin
    ctl_word                 = '0;
    ctl_word[STATE_W-1:0]    = req_state;
    ctl_word[LRST_BIT]       = req_lrst_n;
    stat_word                = '0;
    stat_word[STATE_W-1:0]   = cur_state;
    stat_word[CLKON_BIT]     = clk_en;
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import psc_pkg::*;
#(
  parameter int          N_MOD          = 4,
  parameter int          N_DOM          = 2,
  parameter int          TRANS_CYCLES   = 8,
  parameter logic [31:0] MOD_DOMAIN_MAP = 32'h0000_1100,
  parameter int          AW             = 12,
  parameter int          DW             = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst
);
  logic [N_MOD-1:0]         mctl_we;
  logic [N_DOM-1:0]         dctl_we;
  logic [N_DOM-1:0]         start_req;
  logic [N_DOM-1:0]         dom_busy;
  logic [N_DOM-1:0]         dom_accept;
  logic [N_DOM-1:0]         dom_done;
  logic [N_MOD*DW-1:0]      mctl_words;
  logic [N_MOD*DW-1:0]      mstat_words;
  logic [N_DOM*DW-1:0]      dctl_words;
  logic [N_DOM*DW-1:0]      dstat_words;
  logic [N_MOD*STATE_W-1:0] mod_state_flat;

  psc_regif #(.N_MOD(N_MOD), .N_DOM(N_DOM), .AW(AW), .DW(DW)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .start_bits (bus_wdata[N_DOM-1:0]),
    .mctl_words (mctl_words),
    .mstat_words(mstat_words),
    .dctl_words (dctl_words),
    .dstat_words(dstat_words),
    .dom_busy   (dom_busy),
    .mctl_we    (mctl_we),
    .dctl_we    (dctl_we),
    .start_req  (start_req),
    .bus_rdata  (bus_rdata)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    psc_dom_seq #(.TRANS_CYCLES(TRANS_CYCLES), .DW(DW)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start_req[d]),
      .ctl_we     (dctl_we[d]),
      .ctl_pwr_bit(bus_wdata[0]),
      .busy       (dom_busy[d]),
      .accept     (dom_accept[d]),
      .done       (dom_done[d]),
      .ctl_word   (dctl_words[d*DW +: DW]),
      .stat_word  (dstat_words[d*DW +: DW])
    );
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    localparam int DOM = int'(MOD_DOMAIN_MAP[4*m +: 4]);
    psc_mod_unit #(.DW(DW)) u_mod (
      .clk      (clk),
      .rst      (rst),
      .ctl_we   (mctl_we[m]),
      .wr_state (bus_wdata[STATE_W-1:0]),
      .wr_lrst_n(bus_wdata[LRST_BIT]),
      .accept   (dom_accept[DOM]),
      .done     (dom_done[DOM]),
      .ctl_word (mctl_words[m*DW +: DW]),
      .stat_word(mstat_words[m*DW +: DW]),
      .cur_state(mod_state_flat[m*STATE_W +: STATE_W]),
      .clk_en   (mod_clk_en[m]),
      .mod_rst  (mod_rst[m])
    );
  end
endmodule

// File: rtl/psc_sva.sv
module psc_sva
  import psc_pkg::*;
#(
  parameter int N_MOD        = 4,
  parameter int N_DOM        = 2,
  parameter int TRANS_CYCLES = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_DOM-1:0]         dom_busy,
  input logic [N_DOM-1:0]         dom_done,
  input logic [N_MOD*STATE_W-1:0] mod_state_flat,
  input logic [N_MOD-1:0]         mod_clk_en,
  input logic [N_MOD-1:0]         mod_rst
);
  localparam int CW = $clog2(TRANS_CYCLES + 2);

  for (genvar d = 0; d < N_DOM; d++) begin : g_d
    logic [CW-1:0] busy_len;
    always_ff @(posedge clk) begin
      if (rst) busy_len <= '0;
      else if (dom_busy[d]) busy_len <= busy_len + 1'b1;
      else busy_len <= '0;
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (dom_busy[d] && busy_len < CW'(TRANS_CYCLES - 1)) |=> dom_busy[d]); // R8
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
      (dom_busy[d] && busy_len == CW'(TRANS_CYCLES - 1)) |=> !dom_busy[d]); // R3
  end

  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !(|dom_done) |=> $stable(mod_state_flat)); // R4

  for (genvar m = 0; m < N_MOD; m++) begin : g_m
    AST_CLK_ONLY_ENABLE: assert property (@(posedge clk) disable iff (rst)
      mod_clk_en[m] == (mod_state_flat[m*STATE_W +: STATE_W] == MS_ENABLE)); // R5
    AST_RST_IN_LOW_STATES: assert property (@(posedge clk) disable iff (rst)
      (mod_state_flat[m*STATE_W +: STATE_W] < 6'd2) |-> mod_rst[m]); // R6
  end
endmodule

bind pwr_sleep_ctrl psc_sva #(
  .N_MOD(N_MOD), .N_DOM(N_DOM), .TRANS_CYCLES(TRANS_CYCLES)
) u_psc_sva (
  .clk           (clk),
  .rst           (rst),
  .dom_busy      (dom_busy),
  .dom_done      (dom_done),
  .mod_state_flat(mod_state_flat),
  .mod_clk_en    (mod_clk_en),
  .mod_rst       (mod_rst)
);

// File: tb/tb_pwr_sleep_ctrl.sv
module tb_pwr_sleep_ctrl;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  mod_clk_en;
  logic [3:0]  mod_rst;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  int req_st[4], req_l[4], app_st[4], app_l[4];
  int snap_st[4], snap_l[4];

  always #5 clk = ~clk;

  pwr_sleep_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
  );

  // vector: {module[3:0], state[5:0], lrst_n, exp_clk, exp_rst}
  localparam logic [12:0] VEC [6] = '{
    {4'd0, 6'd3, 1'b1, 1'b1, 1'b0},
    {4'd2, 6'd3, 1'b0, 1'b1, 1'b1},
    {4'd1, 6'd2, 1'b1, 1'b0, 1'b0},
    {4'd3, 6'd1, 1'b1, 1'b0, 1'b1},
    {4'd0, 6'd0, 1'b1, 1'b0, 1'b1},
    {4'd2, 6'd2, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mod(input int m, input int st, input int l);
    wr(12'hA00 + 12'(4*m), 32'(st) | (l != 0 ? 32'h100 : 32'h0));
    req_st[m] = st; req_l[m] = l;
  endtask

  task automatic start_doms(input logic [1:0] dm);
    wr(12'h120, {30'd0, dm});
    for (int m = 0; m < 4; m++)
      if (dm[m/2]) begin snap_st[m] = req_st[m]; snap_l[m] = req_l[m]; end
  endtask

  task automatic wait_idle(input logic [1:0] dm);
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      rd(12'h128, v);
      if ((v[1:0] & dm) == 2'b00) break;
    end
    for (int m = 0; m < 4; m++)
      if (dm[m/2]) begin app_st[m] = snap_st[m]; app_l[m] = snap_l[m]; end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int m = 0; m < 4; m++) begin
      rd(12'h800 + 12'(4*m), v);
      chk({"R4 ", tag}, {26'd0, v[5:0]}, 32'(app_st[m]));
      chk({"R5 ", tag}, {31'd0, v[12]}, {31'd0, app_st[m] == 3});
      chk({"R5 port ", tag}, {31'd0, mod_clk_en[m]}, {31'd0, app_st[m] == 3});
      chk({"R6 ", tag}, {31'd0, mod_rst[m]}, {31'd0, (app_st[m] < 2) || (app_l[m] == 0)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    for (int m = 0; m < 4; m++) begin
      req_st[m] = 0; req_l[m] = 0; app_st[m] = 0; app_l[m] = 0; snap_st[m] = 0; snap_l[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", {28'd0, mod_clk_en}, 32'h0);
    chk("R1 mod_rst", {28'd0, mod_rst}, 32'hF);
    rd(12'h128, v); chk("R1 busy", v, 32'h0);
    for (int m = 0; m < 4; m++) begin
      rd(12'h800 + 12'(4*m), v); chk("R1 mstat", v, 32'h0);
      rd(12'hA00 + 12'(4*m), v); chk("R1 mctl", v, 32'h0);
    end
    for (int d = 0; d < 2; d++) begin
      rd(12'h200 + 12'(4*d), v); chk("R1 dstat", v, 32'h0);
    end

    // R2 control readback mask
    wr(12'hA0C, 32'hFFFF_FFFF);
    rd(12'hA0C, v); chk("R2 mctl mask", v, 32'h0000_013F);
    wr(12'hA0C, 32'h0);
    rd(12'hA0C, v); chk("R2 mctl clear", v, 32'h0);

    // table walk: R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      int m;
      m = int'(VEC[i][12:9]);
      set_mod(m, int'(VEC[i][8:3]), int'(VEC[i][2]));
      start_doms(m < 2 ? 2'b01 : 2'b10);
      wait_idle(2'b11);
      chk("R5 vec clk", {31'd0, mod_clk_en[m]}, {31'd0, VEC[i][1]});
      chk("R6 vec rst", {31'd0, mod_rst[m]}, {31'd0, VEC[i][0]});
      check_all("vector");
    end

    // R3 exact busy window
    wr(12'h120, 32'h1);
    cnt = 0;
    for (int i = 0; i < T + 1; i++) begin
      rd(12'h128, v);
      if (v[0]) cnt++;
    end
    chk("R3 busy cycles", 32'(cnt), 32'(T));
    chk("R3 busy clear", v, 32'h0);

    // R7 domain power state
    wr(12'h300, 32'h1);
    rd(12'h200, v); chk("R7 off before start", v, 32'h0);
    start_doms(2'b01); wait_idle(2'b01);
    rd(12'h200, v); chk("R7 domain on", v[4:0], 32'h1);
    rd(12'h204, v); chk("R7 other domain off", v, 32'h0);
    wr(12'h300, 32'h0);
    start_doms(2'b01); wait_idle(2'b01);
    rd(12'h200, v); chk("R7 domain off", v, 32'h0);

    // R8 and R9: start while busy and control write while busy
    start_doms(2'b10);
    rd(12'h128, v); rd(12'h128, v);
    wr(12'hA08, 32'h103);
    wr(12'h120, 32'h2);
    req_st[2] = 3; req_l[2] = 1;
    cnt = 0;
    for (int i = 0; i < T; i++) begin
      rd(12'h128, v);
      if (v[1]) cnt++;
    end
    chk("R8 window not restarted", 32'(cnt), 32'd4);
    for (int m = 2; m < 4; m++) begin app_st[m] = snap_st[m]; app_l[m] = snap_l[m]; end
    rd(12'h808, v); chk("R9 old snapshot kept", {26'd0, v[5:0]}, 32'(app_st[2]));
    start_doms(2'b10); wait_idle(2'b10);
    rd(12'h808, v); chk("R9 applied at next start", {26'd0, v[5:0]}, 32'h3);
    check_all("R9");

    // R10 both domains in one write
    set_mod(0, 3, 1);
    set_mod(3, 3, 1);
    start_doms(2'b11);
    rd(12'h128, v); chk("R10 both busy", v, 32'h3);
    wait_idle(2'b11);
    rd(12'h128, v); chk("R10 both idle", v, 32'h0);
    check_all("R10");

    // R11 unmapped reads
    rd(12'h400, v); chk("R11 unmapped", v, 32'h0);
    rd(12'h810, v); chk("R11 bad module index", v, 32'h0);
    rd(12'h208, v); chk("R11 bad domain index", v, 32'h0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule